// File: doc/BRIEF.md
# Priority Address Decoding Router

This block takes requests from several initiator ports and sends each one to a single target port. Each target port has its own address window, made of a base address, a size, a priority value and an address-mode flag. A window-settings write port loads these values. When initiators compete, a round-robin arbiter picks one request. The block then looks for every window that holds the request address.

Windows may overlap. The hit with the smallest priority value wins, and among equal priorities the lower target index wins. The block captures the winning request into a hold stage, which presents it to that one target. The forwarded address is either the incoming address unchanged or its offset from the target's base, chosen per target. The request also carries the index of the initiator port it came from.

A request that falls in no window is accepted at once with a decode-error flag and goes to no target. Both edges use valid/ready. An initiator holds its valid, address and data until it sees its ready. The block raises one ready per cycle and only when no request is held. A held request stays on the target port, unchanged, until that target's ready is seen at a clock edge. While it waits, every initiator is stalled.

Top module: `addr_prio_router`

## Requirements
- R1: A target matches an address a when base <= a and a - base < size. A target whose size is 0 never matches.
- R2: Among matching targets, the one with the numerically smallest priority value is chosen.
- R3: Among matching targets with equal priority, the lowest target index is chosen.
- R4: When a target's relative flag is 1, the forwarded address is the request address minus that target's base. When the flag is 0, the address is forwarded unchanged. The data is forwarded unchanged in both cases.
- R5: t_src carries the index, from 0 to N_INI-1, of the initiator port whose request is being presented.
- R6: A request that matches no target is acknowledged in the same cycle with i_ready and i_derr both high on its bit. No t_valid follows it.
- R7: At most one i_ready bit is high per cycle, and only for an initiator whose i_valid is high. The grant search starts one index past the last granted initiator and wraps around.
- R8: A captured request raises exactly one t_valid bit from the cycle after its grant. t_valid, t_addr, t_data and t_src stay unchanged until that target's t_ready is high at a clock edge. No initiator is granted while a request is held.
- R9: A window-settings write that happens while a request is held does not change the held request's target, address or data.
- R10: After reset no t_valid is high and no ready is given without a request. Every target has size 0, priority 0 and the relative flag set, so every request gets a decode error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for window settings |
| cfg_sel | input | TW | Target whose window is written |
| cfg_base | input | AW | Window base address |
| cfg_size | input | AW | Window size in address units |
| cfg_rel | input | 1 | 1 = forward offset from base, 0 = forward absolute address |
| cfg_prio | input | PW | Window priority, smaller wins |
| i_valid | input | N_INI | Request valid, one bit per initiator |
| i_ready | output | N_INI | Request accepted, one bit per initiator |
| i_derr | output | N_INI | Decode error, qualifies i_ready |
| i_addr | input | N_INI x AW | Request address per initiator |
| i_data | input | N_INI x DW | Request payload per initiator |
| t_valid | output | N_TGT | Request presented, one bit per target |
| t_ready | input | N_TGT | Target accepts, one bit per target |
| t_addr | output | AW | Forwarded address |
| t_data | output | DW | Forwarded payload |
| t_src | output | IW | Originating initiator index |

## Verification
The checker watches the handshake rules on every cycle. It confirms there is at most one grant and only to a requester, and that a decode error always comes with a ready. It confirms that no target request follows a decode error, that at most one t_valid is high, and that a held request stays stable until accepted. It also confirms that no grant is given while a request is held, and that the source index stays in range. Which target wins a match, the rewritten address value, the round-robin order, the reset window state and the immunity of a held request to settings writes can only be shown by the bench's scenarios, against its own model of the windows.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int unsigned RT_N_INI = 3;
  localparam int unsigned RT_N_TGT = 4;
  localparam int unsigned RT_AW    = 32;
  localparam int unsigned RT_DW    = 16;
  localparam int unsigned RT_PW    = 4;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned N = router_pkg::RT_N_INI,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    int j;
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < int'(N); k++) begin
      j = int'(ptr_q) + k;
      if (j >= int'(N)) j = j - int'(N);
      if (!gnt_vld && req[j]) begin
        gnt_vld = 1'b1;
        gnt_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (gnt_vld) ptr_q <= (int'(gnt_idx) == int'(N) - 1) ? '0 : gnt_idx + 1'b1;
  end
endmodule

// File: rtl/win_regs.sv
module win_regs #(
  parameter int unsigned M  = router_pkg::RT_N_TGT,
  parameter int unsigned AW = router_pkg::RT_AW,
  parameter int unsigned PW = router_pkg::RT_PW,
  localparam int unsigned TW = (M > 1) ? $clog2(M) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [TW-1:0]        sel,
  input  logic [AW-1:0]        base_in,
  input  logic [AW-1:0]        size_in,
  input  logic                 rel_in,
  input  logic [PW-1:0]        prio_in,
  output logic [M-1:0][AW-1:0] base,
  output logic [M-1:0][AW-1:0] size,
  output logic [M-1:0]         rel,
  output logic [M-1:0][PW-1:0] prio
);
  for (genvar t = 0; t < M; t++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base[t] <= '0;
        size[t] <= '0;
        rel[t]  <= 1'b1;
        prio[t] <= '0;
      end else if (we && int'(sel) == t) begin
        base[t] <= base_in;
        size[t] <= size_in;
        rel[t]  <= rel_in;
        prio[t] <= prio_in;
      end
    end
  end
endmodule

// File: rtl/window_pick.sv
module window_pick #(
  parameter int unsigned M  = router_pkg::RT_N_TGT,
  parameter int unsigned AW = router_pkg::RT_AW,
  parameter int unsigned PW = router_pkg::RT_PW,
  localparam int unsigned TW = (M > 1) ? $clog2(M) : 1
) (
  input  logic [AW-1:0]        addr,
  input  logic [M-1:0][AW-1:0] base,
  input  logic [M-1:0][AW-1:0] size,
  input  logic [M-1:0][PW-1:0] prio,
  output logic                 hit,
  output logic [TW-1:0]        idx
);
  logic [M-1:0] in_win;

  for (genvar t = 0; t < M; t++) begin : g_cmp
    assign in_win[t] = (addr >= base[t]) && ((addr - base[t]) < size[t]);
  end

  always_comb begin
    logic [PW-1:0] best;
    hit  = 1'b0;
    idx  = '0;
    best = '1;
    for (int t = 0; t < int'(M); t++) begin
      if (in_win[t] && (!hit || prio[t] < best)) begin
        hit  = 1'b1;
        idx  = TW'(t);
        best = prio[t];
      end
    end
  end
endmodule

// File: rtl/addr_prio_router.sv
module addr_prio_router #(
  parameter int unsigned N_INI = router_pkg::RT_N_INI,
  parameter int unsigned N_TGT = router_pkg::RT_N_TGT,
  parameter int unsigned AW    = router_pkg::RT_AW,
  parameter int unsigned DW    = router_pkg::RT_DW,
  parameter int unsigned PW    = router_pkg::RT_PW,
  localparam int unsigned IW = (N_INI > 1) ? $clog2(N_INI) : 1,
  localparam int unsigned TW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [TW-1:0]            cfg_sel,
  input  logic [AW-1:0]            cfg_base,
  input  logic [AW-1:0]            cfg_size,
  input  logic                     cfg_rel,
  input  logic [PW-1:0]            cfg_prio,
  input  logic [N_INI-1:0]         i_valid,
  output logic [N_INI-1:0]         i_ready,
  output logic [N_INI-1:0]         i_derr,
  input  logic [N_INI-1:0][AW-1:0] i_addr,
  input  logic [N_INI-1:0][DW-1:0] i_data,
  output logic [N_TGT-1:0]         t_valid,
  input  logic [N_TGT-1:0]         t_ready,
  output logic [AW-1:0]            t_addr,
  output logic [DW-1:0]            t_data,
  output logic [IW-1:0]            t_src
);
  logic [N_TGT-1:0][AW-1:0] w_base, w_size;
  logic [N_TGT-1:0]         w_rel;
  logic [N_TGT-1:0][PW-1:0] w_prio;

  logic                busy_q;
  logic [TW-1:0]       tgt_q;
  logic [AW-1:0]       addr_q;
  logic [DW-1:0]       data_q;
  logic [IW-1:0]       src_q;

  logic                gnt_vld, hit;
  logic [IW-1:0]       gnt_idx;
  logic [TW-1:0]       hit_idx;
  logic [AW-1:0]       req_addr, fwd_addr;
  logic [N_INI-1:0]    arb_req;

  win_regs #(.M(N_TGT), .AW(AW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .base_in(cfg_base), .size_in(cfg_size), .rel_in(cfg_rel), .prio_in(cfg_prio),
    .base(w_base), .size(w_size), .rel(w_rel), .prio(w_prio)
  );

  assign arb_req = busy_q ? '0 : i_valid;

  rr_pick #(.N(N_INI)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(arb_req),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  assign req_addr = i_addr[gnt_idx];

  window_pick #(.M(N_TGT), .AW(AW), .PW(PW)) u_dec (
    .addr(req_addr), .base(w_base), .size(w_size), .prio(w_prio),
    .hit(hit), .idx(hit_idx)
  );

  assign fwd_addr = w_rel[hit_idx] ? (req_addr - w_base[hit_idx]) : req_addr;
  assign i_ready  = gnt_vld ? (N_INI'(1) << gnt_idx) : '0;
  assign i_derr   = (gnt_vld && !hit) ? (N_INI'(1) << gnt_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tgt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      src_q  <= '0;
    end else if (busy_q) begin
      if (t_ready[tgt_q]) busy_q <= 1'b0;
    end else if (gnt_vld && hit) begin
      busy_q <= 1'b1;
      tgt_q  <= hit_idx;
      addr_q <= fwd_addr;
      data_q <= i_data[gnt_idx];
      src_q  <= gnt_idx;
    end
  end

  assign t_valid = busy_q ? (N_TGT'(1) << tgt_q) : '0;
  assign t_addr  = addr_q;
  assign t_data  = data_q;
  assign t_src   = src_q;
endmodule

// File: rtl/router_chk.sv
module router_chk #(
  parameter int unsigned N_INI = router_pkg::RT_N_INI,
  parameter int unsigned N_TGT = router_pkg::RT_N_TGT,
  parameter int unsigned AW    = router_pkg::RT_AW,
  parameter int unsigned DW    = router_pkg::RT_DW,
  localparam int unsigned IW = (N_INI > 1) ? $clog2(N_INI) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_INI-1:0] i_valid,
  input logic [N_INI-1:0] i_ready,
  input logic [N_INI-1:0] i_derr,
  input logic [N_TGT-1:0] t_valid,
  input logic [N_TGT-1:0] t_ready,
  input logic [AW-1:0]    t_addr,
  input logic [DW-1:0]    t_data,
  input logic [IW-1:0]    t_src
);
  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(i_ready));

  a_r7_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (i_ready & ~i_valid) == '0);

  a_r6_derr_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (i_derr & ~i_ready) == '0);

  a_r6_no_forward_after_derr: assert property (@(posedge clk) disable iff (!rst_n)
    (|i_derr) |=> (t_valid == '0));

  a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(t_valid));

  a_r8_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    ((|t_valid) && ((t_valid & t_ready) == '0)) |=>
      (t_valid == $past(t_valid)) && $stable(t_addr) && $stable(t_data) && $stable(t_src));

  a_r8_no_grant_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    (|t_valid) |-> (i_ready == '0));

  a_r5_src_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (|t_valid) |-> (int'(t_src) < int'(N_INI)));
endmodule

bind addr_prio_router router_chk #(
  .N_INI(N_INI), .N_TGT(N_TGT), .AW(AW), .DW(DW)
) u_chk (.*);

// File: tb/addr_prio_router_tb.sv
`timescale 1ns/1ps
module addr_prio_router_tb;
  localparam int NI = 3;
  localparam int NT = 4;
  localparam int AW = 32;
  localparam int DW = 16;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = '0;
  logic [AW-1:0]     cfg_base = '0, cfg_size = '0;
  logic              cfg_rel = 1'b0;
  logic [PW-1:0]     cfg_prio = '0;
  logic [NI-1:0]     i_valid = '0;
  logic [NI-1:0]     i_ready, i_derr;
  logic [NI-1:0][AW-1:0] i_addr = '0;
  logic [NI-1:0][DW-1:0] i_data = '0;
  logic [NT-1:0]     t_valid;
  logic [NT-1:0]     t_ready = '0;
  logic [AW-1:0]     t_addr;
  logic [DW-1:0]     t_data;
  logic [1:0]        t_src;

  addr_prio_router #(.N_INI(NI), .N_TGT(NT), .AW(AW), .DW(DW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_rel(cfg_rel), .cfg_prio(cfg_prio),
    .i_valid(i_valid), .i_ready(i_ready), .i_derr(i_derr), .i_addr(i_addr), .i_data(i_data),
    .t_valid(t_valid), .t_ready(t_ready), .t_addr(t_addr), .t_data(t_data), .t_src(t_src)
  );

  int total = 0;
  int bad = 0;
  logic [AW-1:0] m_base [NT];
  logic [AW-1:0] m_size [NT];
  bit            m_rel  [NT];
  int            m_prio [NT];
  int            ptr_m = 0;

  function automatic void chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endfunction

  function automatic int exp_tgt(logic [AW-1:0] a);
    int best = -1;
    for (int t = 0; t < NT; t++)
      if (a >= m_base[t] && (a - m_base[t]) < m_size[t])
        if (best < 0 || m_prio[t] < m_prio[best]) best = t;
    return best;
  endfunction

  function automatic logic [AW-1:0] exp_addr(int t, logic [AW-1:0] a);
    return m_rel[t] ? a - m_base[t] : a;
  endfunction

  function automatic int exp_grant(logic [NI-1:0] mask);
    for (int k = 0; k < NI; k++) begin
      int j = (ptr_m + k) % NI;
      if (mask[j]) return j;
    end
    return -1;
  endfunction

  task automatic cfg_write(int t, logic [AW-1:0] b, logic [AW-1:0] s, bit r, int p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(t); cfg_base = b; cfg_size = s; cfg_rel = r; cfg_prio = PW'(p);
    @(negedge clk);
    cfg_we = 1'b0;
    m_base[t] = b; m_size[t] = s; m_rel[t] = r; m_prio[t] = p;
  endtask

  task automatic do_req(int ini, logic [AW-1:0] a, logic [DW-1:0] d, int stall, bit reconf, string tag);
    int et;
    logic [AW-1:0] ea;
    @(negedge clk);
    i_valid = '0; i_valid[ini] = 1'b1; i_addr[ini] = a; i_data[ini] = d;
    #1;
    et = exp_tgt(a);
    chk(i_ready == (NI'(1) << ini), "R7", 64'(i_ready), 64'(NI'(1) << ini));
    chk(i_derr == ((et < 0) ? (NI'(1) << ini) : NI'(0)), "R6", 64'(i_derr), 64'(et < 0));
    ptr_m = (ini + 1) % NI;
    @(negedge clk);
    i_valid = '0;
    if (et < 0) begin
      chk(t_valid == '0, "R6", 64'(t_valid), 0);
      return;
    end
    ea = exp_addr(et, a);
    chk(t_valid == (NT'(1) << et), tag, 64'(t_valid), 64'(NT'(1) << et));
    chk(t_addr == ea, "R4", 64'(t_addr), 64'(ea));
    chk(t_data == d, "R4", 64'(t_data), 64'(d));
    chk(t_src == 2'(ini), "R5", 64'(t_src), 64'(ini));
    if (reconf) begin
      cfg_write(et, AW'($urandom_range(0, 'h4FFF)), AW'($urandom_range(0, 'h1000)),
                1'($urandom), $urandom_range(0, 3));
      chk(t_valid == (NT'(1) << et) && t_addr == ea && t_data == d, "R9", 64'(t_addr), 64'(ea));
    end
    for (int s = 0; s < stall; s++) begin
      t_ready = NT'($urandom) & ~(NT'(1) << et);
      @(negedge clk);
      chk(t_valid == (NT'(1) << et) && t_addr == ea && t_src == 2'(ini), "R8",
          64'(t_valid), 64'(NT'(1) << et));
    end
    t_ready = NT'(1) << et;
    @(negedge clk);
    t_ready = '0;
    chk(t_valid == '0, "R8", 64'(t_valid), 0);
  endtask

  initial begin
    #(150000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int t = 0; t < NT; t++) begin
      m_base[t] = '0; m_size[t] = '0; m_rel[t] = 1'b1; m_prio[t] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(t_valid == '0, "R10", 64'(t_valid), 0);
    chk(i_ready == '0, "R10", 64'(i_ready), 0);
    do_req(0, 'h0, 'h11, 0, 0, "R10");
    do_req(1, 'h1234, 'h12, 0, 0, "R10");

    cfg_write(0, 'h1000, 'h100, 1, 0);
    do_req(0, 'h1000, 'hA0, 0, 0, "R1");
    do_req(1, 'h10FF, 'hA1, 2, 0, "R1");
    do_req(2, 'h1100, 'hA2, 0, 0, "R1");
    do_req(0, 'h0FFF, 'hA3, 0, 0, "R1");

    cfg_write(1, 'h1000, 'h1000, 0, 0);
    do_req(1, 'h1050, 'hB0, 1, 0, "R3");
    do_req(2, 'h1800, 'hB1, 0, 0, "R4");

    cfg_write(0, 'h1000, 'h100, 1, 5);
    cfg_write(1, 'h1000, 'h1000, 0, 2);
    do_req(0, 'h1050, 'hC0, 0, 0, "R2");
    cfg_write(2, 'h1000, 'h10, 1, 2);
    do_req(1, 'h1005, 'hC1, 0, 0, "R3");
    cfg_write(3, 'h1000, 'h0, 1, 1);
    do_req(2, 'h1000, 'hC2, 0, 0, "R1");
    cfg_write(2, 'h1000, 'h10, 1, 1);
    do_req(0, 'h1005, 'hC3, 1, 0, "R2");
    do_req(1, 'h1800, 'hC4, 3, 1, "R9");

    for (int c = 0; c < 40; c++) begin
      logic [NI-1:0] mask;
      int g;
      mask = (c < 6) ? '1 : NI'($urandom);
      @(negedge clk);
      i_valid = mask;
      for (int k = 0; k < NI; k++) i_addr[k] = 'hFFFF_0000;
      #1;
      g = exp_grant(mask);
      chk(i_ready == ((g < 0) ? NI'(0) : (NI'(1) << g)), "R7", 64'(i_ready), 64'(g));
      if (g >= 0) ptr_m = (g + 1) % NI;
    end
    @(negedge clk);
    i_valid = '0;

    for (int n = 0; n < 300; n++) begin
      if (n % 25 == 0)
        cfg_write($urandom_range(0, NT - 1), AW'($urandom_range(0, 'h4FFF)),
                  ($urandom_range(0, 4) == 0) ? AW'(0) : AW'($urandom_range(1, 'h1000)),
                  1'($urandom), $urandom_range(0, 3));
      do_req($urandom_range(0, NI - 1), AW'($urandom_range(0, 'h5FFF)), DW'($urandom),
             $urandom_range(0, 3), $urandom_range(0, 7) == 0, "R1");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule